// File: doc/BRIEF.md
# Key-Locked Diagnostic Register Block

This block is a small memory-mapped register set that sits between a host register bus and a chip's diagnostic controls. It shows the processor state in a doorbell register and holds a diagnostic control register. That control register cannot be changed until software writes a fixed six-value key into a sequence register. When the key is complete, a write-enable flag comes up. Software can then drive the reset-control bits, pick a boot source, clear a flash error flag and open an indirect access window.

The window is made of a low address word, a high address word and a data register. When the window is open, every access to the data register turns into a read or write on an internal chip-space port, at the 64-bit address made from the two address words. An adapter reset requested through the control register locks the block again. Software must then replay the key before it can change anything more.

Top module: `diag_keylock_regs`

## Requirements
- R1: After reset the diagnostic register reads 0x0, all control outputs are low, no chip-space access is issued and bus_rdata_o is 0.
- R2: Six back-to-back writes of 0x0, 0x4, 0xB, 0x2, 0x7, 0xD (full 32-bit values) to the sequence register at offset 0x04 set the write-enable flag, which reads as bit 7 of the diagnostic register at offset 0x08.
- R3: A sequence-register write that is not the next expected key value restarts the match. A non-matching write of 0x0 counts as the first key step. Wrong orders, interrupted keys and a wrong final value leave the block locked.
- R4: Reads and writes to other offsets in the middle of a key do not disturb its progress.
- R5: While the write-enable flag is clear, writes to the diagnostic register change no bit of it.
- R6: While unlocked, a diagnostic write stores bit 1 (hold processor in reset, output ioc_hold_o), bit 4 (window enable), bit 9 (forced hold mode, output hold_mode_o) and bits 12:11 (boot source, output boot_sel_o). These bits read back at the same positions.
- R7: An unlocked diagnostic write with bit 2 set pulses adapter_reset_o for one cycle, clears write-enable and window enable, and sets the reset-history flag in bit 5. Bit 2 reads 0. While unlocked, writing 0 to bit 5 clears the history flag.
- R8: A pulse on flash_bad_i sets the flash-error flag in bit 6. An unlocked diagnostic write with bit 10 set clears it. Bit 10 always reads 0.
- R9: A read of offset 0x00 returns ioc_state_i in bits 31:28 and zero in all other bits.
- R10: The address words at offset 0x14 (low) and 0x18 (high) read back what was written. With the window enabled, a write to offset 0x10 issues one cs_wr_o cycle with cs_addr_o = {high, low} and the bus data. A read of offset 0x10 issues cs_rd_o and returns cs_rdata_i.
- R11: With the window enable clear, data-register accesses raise neither cs_rd_o nor cs_wr_o, and reads of offset 0x10 return 0.
- R12: Read data appears on bus_rdata_o in the cycle after bus_rd_i. Unmapped offsets and the sequence register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_rd_i |
| ioc_state_i | input | 4 | Processor state shown in the doorbell |
| flash_bad_i | input | 1 | Sets the flash-error flag |
| adapter_reset_o | output | 1 | One-cycle adapter reset request |
| ioc_hold_o | output | 1 | Hold processor in reset |
| hold_mode_o | output | 1 | Forced hold-on-reset mode |
| boot_sel_o | output | 2 | Boot source select |
| cs_addr_o | output | 64 | Chip-space address |
| cs_wr_o | output | 1 | Chip-space write strobe |
| cs_wdata_o | output | 32 | Chip-space write data |
| cs_rd_o | output | 1 | Chip-space read strobe |
| cs_rdata_i | input | 32 | Chip-space read data, combinational response |

## Verification
The key matcher is driven with five key patterns, and each one separates a different matcher fault:
- The exact order must unlock the block.
- A swapped pair must not unlock it, which catches a matcher that only counts writes.
- A key broken by a stray value must not unlock it, which catches a matcher that skips bad writes instead of restarting.
- A repeated leading 0x0 and a wrong final value that is 0x0 must both be taken as a fresh first step, which catches a restart that does not reuse the offending write.
- A key with unrelated register traffic mixed in checks that only sequence writes move the matcher.

The window is exercised against a behavioural chip-space memory at two addresses, first closed and then open. This separates address composition from data forwarding and from gating by the enable bit.

// File: rtl/diag_pkg.sv
`timescale 1ns/1ps
package diag_pkg;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int KEY_LEN = 6;
  localparam int ST_W    = 4;

  localparam logic [AW-1:0] OFF_BELL = 8'h00;
  localparam logic [AW-1:0] OFF_SEQ  = 8'h04;
  localparam logic [AW-1:0] OFF_DIAG = 8'h08;
  localparam logic [AW-1:0] OFF_DATA = 8'h10;
  localparam logic [AW-1:0] OFF_LO   = 8'h14;
  localparam logic [AW-1:0] OFF_HI   = 8'h18;

  localparam int B_HOLD  = 1;
  localparam int B_RST   = 2;
  localparam int B_RWEN  = 4;
  localparam int B_HIST  = 5;
  localparam int B_FBAD  = 6;
  localparam int B_WEN   = 7;
  localparam int B_HMODE = 9;
  localparam int B_FCLR  = 10;
  localparam int B_BOOT  = 11;

  typedef struct packed {
    logic [1:0] boot;
    logic       hold_mode;
    logic       wr_en;
    logic       flash_bad;
    logic       hist;
    logic       rw_en;
    logic       hold;
  } diag_state_t;

  function automatic logic [DW-1:0] key_word(input int idx);
    case (idx)
      0:       key_word = 32'h0;
      1:       key_word = 32'h4;
      2:       key_word = 32'hB;
      3:       key_word = 32'h2;
      4:       key_word = 32'h7;
      default: key_word = 32'hD;
    endcase
  endfunction
endpackage

// File: rtl/diag_key_matcher.sv
`timescale 1ns/1ps
module diag_key_matcher
  import diag_pkg::*;
#(
  parameter int LEN = KEY_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seq_wr_i,
  input  logic [DW-1:0] seq_data_i,
  output logic          unlock_o
);
  localparam int SW = $clog2(LEN);
  localparam logic [SW-1:0] LAST = SW'(LEN - 1);

  logic [LEN-1:0] hit;
  logic [SW-1:0]  step_q;
  logic           unlock_q;
  logic           hit_exp;

  for (genvar i = 0; i < LEN; i++) begin : g_cmp
    assign hit[i] = (seq_data_i == key_word(i));
  end

  assign hit_exp  = hit[step_q];
  assign unlock_o = unlock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      unlock_q <= 1'b0;
    end else begin
      unlock_q <= 1'b0;
      if (seq_wr_i) begin
        if (hit_exp) begin
          if (step_q == LAST) begin
            step_q   <= '0;
            unlock_q <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end else if (hit[0]) begin
          // offending write may itself start a new key
          step_q <= SW'(1);
        end else begin
          step_q <= '0;
        end
      end
    end
  end

  // R3
  mismatch_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_wr_i && !hit_exp && !hit[0]) |=> (step_q == '0 && !unlock_o));
endmodule

// File: rtl/diag_ctrl_reg.sv
`timescale 1ns/1ps
module diag_ctrl_reg
  import diag_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        wr_hold_i,
  input  logic        wr_rst_i,
  input  logic        wr_rwen_i,
  input  logic        wr_hist_i,
  input  logic        wr_hmode_i,
  input  logic        wr_fclr_i,
  input  logic [1:0]  wr_boot_i,
  input  logic        unlock_i,
  input  logic        flash_bad_i,
  output diag_state_t state_o,
  output logic        adapter_rst_o
);
  diag_state_t st_q;
  logic        rst_q;
  logic        wr_ok;

  assign wr_ok         = wr_i && st_q.wr_en;
  assign state_o       = st_q;
  assign adapter_rst_o = rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (unlock_i) st_q.wr_en <= 1'b1;
      if (wr_ok) begin
        st_q.hold      <= wr_hold_i;
        st_q.rw_en     <= wr_rwen_i;
        st_q.hist      <= st_q.hist & wr_hist_i;
        st_q.hold_mode <= wr_hmode_i;
        st_q.boot      <= wr_boot_i;
        if (wr_fclr_i) st_q.flash_bad <= 1'b0;
        if (wr_rst_i) begin
          rst_q       <= 1'b1;
          st_q.wr_en  <= 1'b0;
          st_q.rw_en  <= 1'b0;
          st_q.hist   <= 1'b1;
        end
      end
      if (flash_bad_i) st_q.flash_bad <= 1'b1;
    end
  end

  // R2
  unlock_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i |=> st_q.wr_en);

  // R5
  locked_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !st_q.wr_en && !flash_bad_i && !unlock_i) |=> $stable(st_q));

  // R7
  reset_relocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> (!st_q.wr_en && !st_q.rw_en && st_q.hist));
endmodule

// File: rtl/diag_window.sv
`timescale 1ns/1ps
module diag_window
  import diag_pkg::*;
#(
  parameter int A_W = AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [A_W-1:0]  addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            rw_en_i,
  output logic [DW-1:0]   lo_o,
  output logic [DW-1:0]   hi_o,
  output logic [2*DW-1:0] cs_addr_o,
  output logic            cs_wr_o,
  output logic [DW-1:0]   cs_wdata_o,
  output logic            cs_rd_o
);
  logic [DW-1:0] lo_q, hi_q;
  logic          data_hit;

  assign data_hit   = (addr_i == A_W'(OFF_DATA));
  assign cs_addr_o  = {hi_q, lo_q};
  assign cs_wdata_o = wdata_i;
  assign cs_wr_o    = wr_i && data_hit && rw_en_i;
  assign cs_rd_o    = rd_i && data_hit && rw_en_i;
  assign lo_o       = lo_q;
  assign hi_o       = hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_W'(OFF_LO)) lo_q <= wdata_i;
      if (addr_i == A_W'(OFF_HI)) hi_q <= wdata_i;
    end
  end

  // R11
  cs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rd_o || cs_wr_o) |-> rw_en_i);

  // R10
  cs_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_wr_o || cs_rd_o) |=> $stable(cs_addr_o));
endmodule

// File: rtl/diag_keylock_regs.sv
`timescale 1ns/1ps
module diag_keylock_regs
  import diag_pkg::*;
#(
  parameter int ADDR_W = AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  input  logic                 bus_rd_i,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic [ST_W-1:0]      ioc_state_i,
  input  logic                 flash_bad_i,
  output logic                 adapter_reset_o,
  output logic                 ioc_hold_o,
  output logic                 hold_mode_o,
  output logic [1:0]           boot_sel_o,
  output logic [2*DW-1:0]      cs_addr_o,
  output logic                 cs_wr_o,
  output logic [DW-1:0]        cs_wdata_o,
  output logic                 cs_rd_o,
  input  logic [DW-1:0]        cs_rdata_i
);
  diag_state_t   st;
  logic          unlock;
  logic          seq_wr, diag_wr;
  logic [DW-1:0] lo, hi, diag_word, rd_mux, rdata_q;

  assign seq_wr  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_SEQ));
  assign diag_wr = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_DIAG));

  diag_key_matcher #(.LEN(KEY_LEN)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seq_wr_i   (seq_wr),
    .seq_data_i (bus_wdata_i),
    .unlock_o   (unlock)
  );

  diag_ctrl_reg u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (diag_wr),
    .wr_hold_i     (bus_wdata_i[B_HOLD]),
    .wr_rst_i      (bus_wdata_i[B_RST]),
    .wr_rwen_i     (bus_wdata_i[B_RWEN]),
    .wr_hist_i     (bus_wdata_i[B_HIST]),
    .wr_hmode_i    (bus_wdata_i[B_HMODE]),
    .wr_fclr_i     (bus_wdata_i[B_FCLR]),
    .wr_boot_i     (bus_wdata_i[B_BOOT+1:B_BOOT]),
    .unlock_i      (unlock),
    .flash_bad_i   (flash_bad_i),
    .state_o       (st),
    .adapter_rst_o (adapter_reset_o)
  );

  diag_window #(.A_W(ADDR_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rw_en_i    (st.rw_en),
    .lo_o       (lo),
    .hi_o       (hi),
    .cs_addr_o  (cs_addr_o),
    .cs_wr_o    (cs_wr_o),
    .cs_wdata_o (cs_wdata_o),
    .cs_rd_o    (cs_rd_o)
  );

  assign ioc_hold_o  = st.hold;
  assign hold_mode_o = st.hold_mode;
  assign boot_sel_o  = st.boot;

  always_comb begin
    diag_word                       = '0;
    diag_word[B_HOLD]               = st.hold;
    diag_word[B_RWEN]               = st.rw_en;
    diag_word[B_HIST]               = st.hist;
    diag_word[B_FBAD]               = st.flash_bad;
    diag_word[B_WEN]                = st.wr_en;
    diag_word[B_HMODE]              = st.hold_mode;
    diag_word[B_BOOT+1:B_BOOT]      = st.boot;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == ADDR_W'(OFF_BELL))      rd_mux[DW-1:DW-ST_W] = ioc_state_i;
    else if (bus_addr_i == ADDR_W'(OFF_DIAG)) rd_mux = diag_word;
    else if (bus_addr_i == ADDR_W'(OFF_LO))   rd_mux = lo;
    else if (bus_addr_i == ADDR_W'(OFF_HI))   rd_mux = hi;
    else if (bus_addr_i == ADDR_W'(OFF_DATA)) rd_mux = st.rw_en ? cs_rdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
    else               rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;

  // R12
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> (bus_rdata_o == '0));

  // R7
  reset_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adapter_reset_o |=> !adapter_reset_o);
endmodule

// File: tb/diag_keylock_regs_test.sv
`timescale 1ns/1ps
module diag_keylock_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  ioc_state = '0;
  logic        flash_bad = 1'b0;
  logic        arst, hold, hmode;
  logic [1:0]  boot;
  logic [63:0] cs_addr;
  logic        cs_wr, cs_rd;
  logic [31:0] cs_wdata, cs_rdata;

  int checks = 0, fails = 0, cs_cnt = 0;
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;
  logic [63:0] last_cs_addr = '0;
  logic [31:0] mem [16];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  diag_keylock_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .ioc_state_i(ioc_state), .flash_bad_i(flash_bad),
    .adapter_reset_o(arst), .ioc_hold_o(hold), .hold_mode_o(hmode),
    .boot_sel_o(boot), .cs_addr_o(cs_addr), .cs_wr_o(cs_wr),
    .cs_wdata_o(cs_wdata), .cs_rd_o(cs_rd), .cs_rdata_i(cs_rdata)
  );

  // behavioural chip-space memory
  assign cs_rdata = mem[cs_addr[5:2]];
  initial for (int i = 0; i < 16; i++) mem[i] = 32'h0;
  always @(posedge clk) begin
    if (cs_wr) mem[cs_addr[5:2]] <= cs_wdata;
    if (cs_wr || cs_rd) begin
      cs_cnt <= cs_cnt + 1;
      last_cs_addr <= cs_addr;
    end
    rd_seen <= rd;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("monitor: unexpected read data", 64'(rdata), 64'hX);
      end else begin
        check(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic key(input logic [31:0] k0, input logic [31:0] k1, input logic [31:0] k2,
                     input logic [31:0] k3, input logic [31:0] k4, input logic [31:0] k5);
    bus_write(8'h04, k0); bus_write(8'h04, k1); bus_write(8'h04, k2);
    bus_write(8'h04, k3); bus_write(8'h04, k4); bus_write(8'h04, k5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rdata", 64'(rdata), 0);
    check("R1 outputs", 64'({arst, hold, hmode, boot, cs_wr, cs_rd}), 0);
    bus_read(8'h08, 32'h0, "R1 diag after reset");
    // R9 doorbell
    ioc_state = 4'h1;
    bus_read(8'h00, 32'h1000_0000, "R9 doorbell ready");
    ioc_state = 4'h4;
    bus_read(8'h00, 32'h4000_0000, "R9 doorbell fault");
    // R5 locked write ignored
    bus_write(8'h08, 32'h0000_1A12);
    bus_read(8'h08, 32'h0, "R5 locked diag write");
    check("R5 hold output locked", 64'({hold, hmode, boot}), 0);
    // R3 wrong order
    key(0, 4, 2, 32'hB, 7, 32'hD);
    bus_read(8'h08, 32'h0, "R3 swapped key");
    // R3 interrupted key
    bus_write(8'h04, 0); bus_write(8'h04, 4); bus_write(8'h04, 32'hB);
    bus_write(8'h04, 5);
    bus_write(8'h04, 2); bus_write(8'h04, 7); bus_write(8'h04, 32'hD);
    bus_read(8'h08, 32'h0, "R3 interrupted key");
    // R3 wrong final value 0 restarts as step one
    key(0, 4, 32'hB, 2, 7, 0);
    bus_read(8'h08, 32'h0, "R3 wrong final value");
    key(4, 32'hB, 2, 7, 32'hD, 32'h0);
    bus_read(8'h08, 32'h80, "R3 zero restart then key");
    // R12 seq register and unmapped reads
    bus_read(8'h04, 32'h0, "R12 sequence register reads zero");
    bus_read(8'h20, 32'h0, "R12 unmapped offset");
    // R6 unlocked write
    bus_write(8'h08, 32'h0000_0A02);
    bus_read(8'h08, 32'h0A82, "R6 diag readback");
    check("R6 outputs", 64'({hold, hmode, boot}), 64'b1101);
    // R11 window closed
    base = cs_cnt;
    bus_write(8'h18, 32'h1);
    bus_write(8'h14, 32'hC000_0008);
    bus_write(8'h10, 32'h1111_2222);
    bus_read(8'h10, 32'h0, "R11 closed data read");
    check("R11 no forwarding", 64'(cs_cnt - base), 0);
    // R10 window open
    bus_write(8'h08, 32'h0000_0A12);
    bus_read(8'h08, 32'h0A92, "R10 rw enable set");
    bus_write(8'h10, 32'hDEAD_BEEF);
    check("R10 forwarded address", last_cs_addr, 64'h1_C000_0008);
    check("R10 memory written", 64'(mem[2]), 64'hDEAD_BEEF);
    bus_read(8'h14, 32'hC000_0008, "R10 low address readback");
    bus_read(8'h18, 32'h1, "R10 high address readback");
    bus_read(8'h10, 32'hDEAD_BEEF, "R10 data read");
    bus_write(8'h14, 32'hC000_000C);
    bus_write(8'h10, 32'h1234_5678);
    bus_read(8'h10, 32'h1234_5678, "R10 second address");
    bus_write(8'h14, 32'hC000_0008);
    bus_read(8'h10, 32'hDEAD_BEEF, "R10 first address kept");
    // R8 flash flag
    @(negedge clk); flash_bad = 1'b1;
    @(negedge clk); flash_bad = 1'b0;
    bus_read(8'h08, 32'h0AD2, "R8 flash flag set");
    bus_write(8'h08, 32'h0000_0E12);
    bus_read(8'h08, 32'h0A92, "R8 flash flag cleared");
    // R7 adapter reset
    bus_write(8'h08, 32'h0000_0A16);
    check("R7 reset pulse", 64'(arst), 1);
    @(negedge clk);
    check("R7 reset pulse one cycle", 64'(arst), 0);
    bus_read(8'h08, 32'h0A22, "R7 relocked with history");
    base = cs_cnt;
    bus_read(8'h10, 32'h0, "R7 window closed by reset");
    check("R7 no forwarding after reset", 64'(cs_cnt - base), 0);
    bus_write(8'h08, 32'h0);
    bus_read(8'h08, 32'h0A22, "R5 locked after reset");
    // R4 interleaved traffic during key
    bus_write(8'h04, 0);
    bus_write(8'h18, 32'h2);
    bus_write(8'h04, 4);
    bus_read(8'h00, 32'h4000_0000, "R4 doorbell mid key");
    bus_write(8'h04, 32'hB); bus_write(8'h08, 32'h0);
    bus_write(8'h04, 2); bus_write(8'h04, 7); bus_write(8'h04, 32'hD);
    bus_read(8'h08, 32'h0AA2, "R4 unlocked with interleaved traffic");
    // R7 history cleared by writing zero
    bus_write(8'h08, 32'h0000_0A02);
    bus_read(8'h08, 32'h0A82, "R7 history cleared");
    repeat (3) @(negedge clk);
    check("scoreboard drained", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule